// File: doc/BRIEF.md
# Shader Upload Register Port

This block sits behind a register write bus. It fills the two on-chip stores of a programmable vertex unit. The first is a program buffer with 512 words. The second is a table of 128 operand descriptors, each 32 bits wide. Each store keeps its own write pointer. Software first loads a pointer through that store's index register. It then streams words into the store through a small window of data addresses. Every accepted data word lands at the current pointer, and the pointer then steps forward and wraps at the depth of its store. The eight data addresses of a window are aliases: every one of them feeds the same pointer.

A write of a nonzero value to the transfer-end register raises a registered pulse one cycle long. Downstream logic uses this pulse to take over the buffered program. Each store has a combinational read port, so a consumer can fetch any entry it needs.

The write bus has no back-pressure. Every write strobe is accepted in the cycle it is presented, so there is no ready signal and no write can stall. The read ports are plain address and data pins with no handshake.

Top module: `shader_upload_port`

## Requirements
- R1: After reset, both stores read as zero at every address, both pointers are zero, and `finalize` is low.
- R2: A write to address 0x2D5 loads the descriptor pointer with bits [6:0] of the written value. All higher bits are ignored.
- R3: A write to any address from 0x2D6 to 0x2DD stores the data at the descriptor pointer, and the pointer then increments by one.
- R4: The descriptor pointer wraps from 127 to 0.
- R5: A write to address 0x2CB loads the program pointer with bits [10:2] of the written value. This is the byte offset divided by 4, taken modulo 512.
- R6: A write to any address from 0x2CC to 0x2D3 stores the data at the program pointer, and the pointer then increments modulo 512, wrapping from 511 to 0.
- R7: A write of a nonzero value to address 0x2BF drives `finalize` high for exactly the one cycle after the write edge.
- R8: A write of zero to address 0x2BF leaves `finalize` low.
- R9: A write to any other address, or any cycle with `wr_en` low, leaves both stores and both pointers unchanged.
- R10: Each read port returns the current content of the addressed entry in the same cycle, with no register in the path.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe, one cycle per write |
| wr_addr | input | 10 | Register address |
| wr_data | input | 32 | Write data |
| prog_rd_addr | input | 9 | Program buffer read address |
| prog_rd_data | output | 32 | Program buffer read data |
| desc_rd_addr | input | 7 | Descriptor table read address |
| desc_rd_data | output | 32 | Descriptor table read data |
| finalize | output | 1 | One-cycle pulse after a nonzero transfer-end write |

## Verification
The bench builds the block with its default parameters: a program depth of 512, a descriptor depth of 128, 32-bit data and the default addresses. At these depths the wrap of each pointer is only a few writes away once the index register has been loaded near the top of the store. The index values used carry junk in their upper bits and, for the program pointer, in the byte-offset bits. The data words go through every alias address of both windows, so a decoder that drops one alias or widens the window shows up as a misplaced word in the read-back.

// File: rtl/shader_upload_pkg.sv
package shader_upload_pkg;
  typedef enum logic [2:0] {
    OP_NONE,
    OP_PROG_IDX,
    OP_PROG_DATA,
    OP_DESC_IDX,
    OP_DESC_DATA,
    OP_XFER_END
  } upl_op_e;
endpackage

// File: rtl/upload_decode.sv
module upload_decode
  import shader_upload_pkg::*;
#(
  parameter int ADDR_W         = 10,
  parameter int PROG_IDX_ADDR  = 'h2CB,
  parameter int PROG_DATA_BASE = 'h2CC,
  parameter int DESC_IDX_ADDR  = 'h2D5,
  parameter int DESC_DATA_BASE = 'h2D6,
  parameter int XFER_END_ADDR  = 'h2BF,
  parameter int WIN_SIZE       = 8
) (
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  output upl_op_e           op
);
  localparam int PROG_DATA_LAST = PROG_DATA_BASE + WIN_SIZE - 1;
  localparam int DESC_DATA_LAST = DESC_DATA_BASE + WIN_SIZE - 1;

  int unsigned a;

  always_comb begin
    a  = int'(wr_addr);
    op = OP_NONE;
    if (wr_en) begin
      if (a == PROG_IDX_ADDR)                                  op = OP_PROG_IDX;
      else if (a >= PROG_DATA_BASE && a <= PROG_DATA_LAST)     op = OP_PROG_DATA;
      else if (a == DESC_IDX_ADDR)                             op = OP_DESC_IDX;
      else if (a >= DESC_DATA_BASE && a <= DESC_DATA_LAST)     op = OP_DESC_DATA;
      else if (a == XFER_END_ADDR)                             op = OP_XFER_END;
    end
  end
endmodule

// File: rtl/upload_ptr_mem.sv
module upload_ptr_mem #(
  parameter int DEPTH     = 128,
  parameter int DATA_W    = 32,
  parameter int IDX_SHIFT = 0,
  localparam int PTR_W    = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              idx_ld,
  input  logic              data_wr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [PTR_W-1:0]  rd_addr,
  output logic [DATA_W-1:0] rd_data
);
  logic [PTR_W-1:0]  ptr;
  logic [DATA_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0]  idx_field;

  assign idx_field = wdata[IDX_SHIFT +: PTR_W];

  // An index load wins over a data write if both are ever raised together.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ptr <= '0;
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (idx_ld) begin
      ptr <= idx_field;
    end else if (data_wr) begin
      mem[ptr] <= wdata;
      ptr      <= ptr + 1'b1;
    end
  end

  assign rd_data = mem[rd_addr];

  // R2
  idx_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    idx_ld |=> ptr == $past(wdata[IDX_SHIFT +: PTR_W]));

  // R3
  store_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (data_wr && !idx_ld) |=> (mem[$past(ptr)] == $past(wdata)) &&
                             (ptr == PTR_W'($past(ptr) + 1)));

  // R9
  ptr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!data_wr && !idx_ld) |=> $stable(ptr));
endmodule

// File: rtl/shader_upload_port.sv
module shader_upload_port
  import shader_upload_pkg::*;
#(
  parameter int ADDR_W         = 10,
  parameter int DATA_W         = 32,
  parameter int PROG_DEPTH     = 512,
  parameter int DESC_DEPTH     = 128,
  parameter int PROG_IDX_ADDR  = 'h2CB,
  parameter int PROG_DATA_BASE = 'h2CC,
  parameter int DESC_IDX_ADDR  = 'h2D5,
  parameter int DESC_DATA_BASE = 'h2D6,
  parameter int XFER_END_ADDR  = 'h2BF,
  parameter int WIN_SIZE       = 8,
  localparam int PROG_W        = $clog2(PROG_DEPTH),
  localparam int DESC_W        = $clog2(DESC_DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [PROG_W-1:0] prog_rd_addr,
  output logic [DATA_W-1:0] prog_rd_data,
  input  logic [DESC_W-1:0] desc_rd_addr,
  output logic [DATA_W-1:0] desc_rd_data,
  output logic              finalize
);
  upl_op_e op;
  logic    fin_d;

  upload_decode #(
    .ADDR_W(ADDR_W), .PROG_IDX_ADDR(PROG_IDX_ADDR), .PROG_DATA_BASE(PROG_DATA_BASE),
    .DESC_IDX_ADDR(DESC_IDX_ADDR), .DESC_DATA_BASE(DESC_DATA_BASE),
    .XFER_END_ADDR(XFER_END_ADDR), .WIN_SIZE(WIN_SIZE)
  ) u_dec (
    .wr_en(wr_en), .wr_addr(wr_addr), .op(op)
  );

  // Program pointer takes a byte offset, so the word index starts at bit 2.
  upload_ptr_mem #(.DEPTH(PROG_DEPTH), .DATA_W(DATA_W), .IDX_SHIFT(2)) u_prog (
    .clk(clk), .rst_n(rst_n),
    .idx_ld(op == OP_PROG_IDX), .data_wr(op == OP_PROG_DATA),
    .wdata(wr_data), .rd_addr(prog_rd_addr), .rd_data(prog_rd_data)
  );

  upload_ptr_mem #(.DEPTH(DESC_DEPTH), .DATA_W(DATA_W), .IDX_SHIFT(0)) u_desc (
    .clk(clk), .rst_n(rst_n),
    .idx_ld(op == OP_DESC_IDX), .data_wr(op == OP_DESC_DATA),
    .wdata(wr_data), .rd_addr(desc_rd_addr), .rd_data(desc_rd_data)
  );

  assign fin_d = (op == OP_XFER_END) && (wr_data != '0);

  always_ff @(posedge clk) begin
    if (!rst_n) finalize <= 1'b0;
    else        finalize <= fin_d;
  end

  // R7
  fin_fire_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && int'(wr_addr) == XFER_END_ADDR && wr_data != '0) |=> finalize);

  // R8
  fin_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && int'(wr_addr) == XFER_END_ADDR && wr_data == '0) |=> !finalize);

  // R7
  fin_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en) |=> !finalize);
endmodule

// File: tb/sim_shader_upload_port.sv
`timescale 1ns/1ps
module sim_shader_upload_port;
  localparam int CLK_NS = 20;

  logic        clk = 0;
  logic        rst_n = 0;
  logic        wr_en = 0;
  logic [9:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [8:0]  prog_rd_addr = '0;
  logic [31:0] prog_rd_data;
  logic [6:0]  desc_rd_addr = '0;
  logic [31:0] desc_rd_data;
  logic        finalize;

  shader_upload_port u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .prog_rd_addr(prog_rd_addr), .prog_rd_data(prog_rd_data),
    .desc_rd_addr(desc_rd_addr), .desc_rd_data(desc_rd_data), .finalize(finalize)
  );

  always #(CLK_NS/2) clk = ~clk;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // bench model, built from the requirements
  logic [31:0] m_prog [512];
  logic [31:0] m_desc [128];
  logic [8:0]  m_pptr = '0;
  logic [6:0]  m_dptr = '0;

  typedef struct {
    bit          is_desc;
    int          addr;
    logic [31:0] exp;
    string       tag;
  } sb_item_t;

  sb_item_t sbq[$];
  bit busy = 0;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // monitor: pops expected items and compares read-port results
  initial begin
    forever begin
      @(negedge clk);
      while (sbq.size() != 0) begin
        sb_item_t it;
        busy = 1;
        it = sbq.pop_front();
        if (it.is_desc) begin
          desc_rd_addr = it.addr[6:0];
          #1;
          check(it.tag, desc_rd_data, it.exp);
        end else begin
          prog_rd_addr = it.addr[8:0];
          #1;
          check(it.tag, prog_rd_data, it.exp);
        end
      end
      busy = 0;
    end
  end

  task automatic expect_rd(input bit is_desc, input int addr, input string tag);
    sb_item_t it;
    it.is_desc = is_desc;
    it.addr    = addr;
    it.exp     = is_desc ? m_desc[addr] : m_prog[addr];
    it.tag     = tag;
    sbq.push_back(it);
  endtask

  task automatic drain();
    @(negedge clk);
    wait (sbq.size() == 0 && !busy);
  endtask

  // driver: one write, model updated per the requirements
  task automatic bus_wr(input int addr, input logic [31:0] data, input bit en = 1);
    @(negedge clk);
    wr_en = en; wr_addr = addr[9:0]; wr_data = data;
    @(posedge clk);
    #1;
    wr_en = 0;
    if (en) begin
      if (addr == 'h2D5) m_dptr = data[6:0];
      else if (addr >= 'h2D6 && addr <= 'h2DD) begin m_desc[m_dptr] = data; m_dptr = m_dptr + 1'b1; end
      else if (addr == 'h2CB) m_pptr = data[10:2];
      else if (addr >= 'h2CC && addr <= 'h2D3) begin m_prog[m_pptr] = data; m_pptr = m_pptr + 1'b1; end
    end
  endtask

  initial begin
    #(CLK_NS * 200000);
    errors++;
    checks++;
    $display("FAIL watchdog: run did not finish actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    for (int i = 0; i < 512; i++) m_prog[i] = '0;
    for (int i = 0; i < 128; i++) m_desc[i] = '0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;

    // R1 reset state
    #1 check("R1 finalize", {31'b0, finalize}, 32'h0);
    expect_rd(0, 0, "R1 prog[0]");
    expect_rd(0, 511, "R1 prog[511]");
    expect_rd(1, 0, "R1 desc[0]");
    expect_rd(1, 127, "R1 desc[127]");
    drain();
    // R1 pointers at zero: the first data words land at entry 0
    bus_wr('h2D6, 32'hD0D0_0001);
    bus_wr('h2CC, 32'hC0C0_0001);
    expect_rd(1, 0, "R1 desc ptr");
    expect_rd(0, 0, "R1 prog ptr");
    drain();

    // R2 index load with junk in the high bits, R3 through every alias
    bus_wr('h2D5, 32'hFFFF_FF85);
    for (int k = 0; k < 8; k++) bus_wr('h2D6 + k, 32'hA500_0000 + k);
    for (int k = 5; k < 13; k++) expect_rd(1, k, "R3 desc alias");
    expect_rd(1, 4, "R2 desc below start");
    drain();

    // R4 wrap of descriptor pointer
    bus_wr('h2D5, 32'h0000_007E);
    bus_wr('h2DA, 32'h1111_1111);
    bus_wr('h2DD, 32'h2222_2222);
    bus_wr('h2D6, 32'h3333_3333);
    expect_rd(1, 126, "R4 desc[126]");
    expect_rd(1, 127, "R4 desc[127]");
    expect_rd(1, 0, "R4 desc[0] after wrap");
    drain();

    // R5 byte offset to word index, R6 wrap
    bus_wr('h2CB, 32'h0000_07F8);
    bus_wr('h2CC, 32'hB000_0001);
    bus_wr('h2D3, 32'hB000_0002);
    bus_wr('h2CF, 32'hB000_0003);
    expect_rd(0, 510, "R5 prog[510]");
    expect_rd(0, 511, "R6 prog[511]");
    expect_rd(0, 0, "R6 prog[0] after wrap");
    drain();
    bus_wr('h2CB, 32'h0000_1237);
    for (int k = 0; k < 8; k++) bus_wr('h2CC + k, 32'hC100_0000 + k);
    for (int k = 'h8D; k < 'h95; k++) expect_rd(0, k, "R6 prog alias");
    drain();

    // R9 unrelated addresses and idle strobe
    bus_wr('h2D4, 32'hDEAD_0001);
    bus_wr('h2DE, 32'hDEAD_0002);
    bus_wr('h2CA, 32'hDEAD_0003);
    bus_wr('h2D6, 32'hDEAD_0004, 0);
    bus_wr('h2CC, 32'hDEAD_0005, 0);
    bus_wr('h2D5, 32'h0000_0040, 0);
    bus_wr('h2D6, 32'h9999_0001);
    bus_wr('h2CC, 32'h9999_0002);
    expect_rd(1, 2, "R9 desc ptr kept");
    expect_rd(1, 1, "R9 desc kept");
    expect_rd(0, 'h95, "R9 prog ptr kept");
    expect_rd(0, 'h94, "R9 prog kept");
    drain();

    // R10 combinational read: value seen one step after an address change
    @(negedge clk);
    desc_rd_addr = 7'd9;
    #1 check("R10 desc read", desc_rd_data, 32'hA500_0004);
    prog_rd_addr = 9'd510;
    #1 check("R10 prog read", prog_rd_data, 32'hB000_0001);

    // R7 finalize pulse
    bus_wr('h2BF, 32'h0000_0001);
    check("R7 pulse high", {31'b0, finalize}, 32'h1);
    @(posedge clk); #1;
    check("R7 pulse one cycle", {31'b0, finalize}, 32'h0);
    bus_wr('h2BF, 32'h8000_0000);
    check("R7 pulse high msb", {31'b0, finalize}, 32'h1);
    @(posedge clk); #1;
    check("R7 pulse ends", {31'b0, finalize}, 32'h0);

    // R8 zero write
    bus_wr('h2BF, 32'h0000_0000);
    check("R8 no pulse", {31'b0, finalize}, 32'h0);
    @(posedge clk); #1;
    check("R8 still low", {31'b0, finalize}, 32'h0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule